// File: doc/BRIEF.md
# Circular Buffer Rollover Interrupt Monitor

This block watches the write pointers of four ring regions that share one memory: the terminal's data circular buffer (one pointer serves both transmit and receive subaddresses), the terminal's command descriptor stack, the monitor's command stack and the monitor's data stack. Each region has an internal offset counter that the message processor advances one word at a time. When an offset crosses the middle of its region a half-rollover event occurs. When it wraps from the last word back to offset zero a full-rollover event occurs. Splitting the events this way lets the host drain the half that was just filled while the hardware writes into the other half, and then swap halves at the wrap.

Every event can set a sticky status bit, but only while its mask bit is 1. The host clears status bits by writing ones. A single interrupt request output is high while any status bit is pending and unmasked. Each region's size is chosen at run time as a power of two between 128 and 8192 words.

Top module: `rollover_irq_monitor`

## Requirements
- R1: Each cycle with `adv_i[r]` high increments region r's offset by one, modulo the region size; the offset is visible on `ptr_o[r*13 +: 13]`.
- R2: The 3-bit size code n for region r (`size_sel_i[r*3 +: 3]`) selects a region of 2^(7+n) words; codes 6 and 7 both select 8192 words.
- R3: When region r's offset moves from size/2-1 to size/2, status bit r (half-rollover) is set, provided mask bit r is 1.
- R4: When the offset of region 0 or 1 moves from size-1 to 0, status bit 4+r (full-rollover) is set, provided its mask bit is 1. Regions 2 and 3 have no full-rollover bit: bits 6 and 7 of `mask_o` and `status_o` always read 0.
- R5: An event whose mask bit is 0 sets nothing, and setting the mask bit later does not raise the status bit for that past event.
- R6: A clear write sets to 0 each status bit whose `clr_wdata_i` bit is 1 and leaves the other bits unchanged.
- R7: If an event and a clear write of the same bit occur in the same cycle, the bit ends up set.
- R8: `irq_o` is the OR of (status AND mask). Clearing a mask bit drops the request but leaves the status bit pending.
- R9: Events that occur in the same cycle on different regions are all recorded.
- R10: After reset all offsets, the mask, the status and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel_i | input | 12 | 3-bit size code per region |
| adv_i | input | 4 | Pointer advance, one bit per region |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 8 | New mask value |
| clr_we_i | input | 1 | Write strobe for clearing status bits |
| clr_wdata_i | input | 8 | Write-one-to-clear pattern |
| mask_o | output | 8 | Current mask (half bits 3:0, full bits 7:4) |
| status_o | output | 8 | Sticky status (half bits 3:0, full bits 7:4) |
| ptr_o | output | 52 | 13-bit offset per region |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: four regions, full rollover on regions 0 and 1 only, and offsets of 13 bits. At first the regions are sized at 128, 256, 128 and 512 words, so every midpoint and wrap, including a run that wraps and crosses the midpoint again, is reached within a few hundred advances. Later region 3 is switched to codes 6 and 7, which brings the 8192-word midpoint and its wrap into reach. The regions without a full-rollover bit show that a wrap there leaves bits 6 and 7 at 0.

// File: rtl/rim_pkg.sv
// Package: shared constants and types for the rollover interrupt monitor.
// Assumes one offset width wide enough for the largest region.
package rim_pkg;
    localparam int NREG     = 4;
    localparam int MIN_LOG2 = 7;
    localparam int MAX_LOG2 = 13;
    localparam int SEL_W    = 3;
    localparam int PTR_W    = MAX_LOG2;

    typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/rim_region_tracker.sv
// Module: rim_region_tracker
// Holds one region's write offset and detects the midpoint crossing and the wrap.
// Assumes the size code is stable while the region is in use; the offset is
// always taken modulo the current size.
module rim_region_tracker #(
    parameter int MIN_LOG2 = 7,
    parameter int MAX_LOG2 = 13,
    parameter int SEL_W    = 3,
    localparam int PTR_W   = MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             adv_i,
    output logic [PTR_W-1:0] off_o,
    output logic             half_evt_o,
    output logic             wrap_evt_o
);
    localparam logic [PTR_W:0] ONE_W = {{PTR_W{1'b0}}, 1'b1};

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] span;
    logic [PTR_W-1:0] half_bit;
    logic [PTR_W-1:0] cur;
    logic [PTR_W-1:0] nxt;
    logic [PTR_W:0]   wide;
    int               lg;

    // Decode the size code into a wrap mask and the midpoint bit.
    always_comb begin
        lg = MIN_LOG2 + int'(sel_i);
        if (lg > MAX_LOG2) begin
            lg = MAX_LOG2;
        end
        wide     = ONE_W << lg;
        span     = PTR_W'(wide - ONE_W);
        half_bit = PTR_W'(wide >> 1);
    end

    // Compute the next offset and both crossing events.
    always_comb begin
        cur        = ptr_q & span;
        nxt        = (cur + 1'b1) & span;
        half_evt_o = adv_i && ((nxt & half_bit) != '0) && ((cur & half_bit) == '0);
        wrap_evt_o = adv_i && (nxt == '0);
    end

    // Offset register: advances once per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            ptr_q <= nxt;
        end
    end

    assign off_o = cur;
endmodule

// File: rtl/rim_status_bank.sv
// Module: rim_status_bank
// Mask register and sticky write-one-to-clear status register.
// Assumes status layout: half events in the low NREG bits, full events above.
// A set in the same cycle as a clear of that bit wins.
module rim_status_bank #(
    parameter int                NREG    = 4,
    parameter logic [NREG-1:0]   FULL_EN = 4'b0011,
    localparam int               STAT_W  = 2 * NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   half_evt_i,
    input  logic [NREG-1:0]   wrap_evt_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    input  logic              clr_we_i,
    input  logic [STAT_W-1:0] clr_wdata_i,
    output logic [STAT_W-1:0] mask_o,
    output logic [STAT_W-1:0] status_o
);
    localparam logic [STAT_W-1:0] VALID = {FULL_EN, {NREG{1'b1}}};

    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;

    // Gate the raw events with the current mask and form the clear pattern.
    always_comb begin
        set_v = {wrap_evt_i, half_evt_i} & mask_q & VALID;
        clr_v = clr_we_i ? clr_wdata_i : '0;
    end

    // Mask register: only implemented bits are writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i & VALID;
        end
    end

    // Sticky status: clear first, then set so that a new event is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_v) | set_v;
        end
    end

    assign mask_o   = mask_q;
    assign status_o = status_q;
endmodule

// File: rtl/rollover_irq_monitor.sv
// Module: rollover_irq_monitor (top)
// Tracks NREG ring-region write offsets and raises half and full rollover
// interrupts through a mask and sticky status register.
// Assumes region 0 is the data circular buffer, 1 the command stack,
// 2 the monitor command stack and 3 the monitor data stack.
module rollover_irq_monitor #(
    parameter int                       NREG     = rim_pkg::NREG,
    parameter int                       MIN_LOG2 = rim_pkg::MIN_LOG2,
    parameter int                       MAX_LOG2 = rim_pkg::MAX_LOG2,
    parameter int                       SEL_W    = rim_pkg::SEL_W,
    parameter logic [NREG-1:0]          FULL_EN  = 4'b0011,
    localparam int                      PTR_W    = MAX_LOG2,
    localparam int                      STAT_W   = 2 * NREG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG*SEL_W-1:0]   size_sel_i,
    input  logic [NREG-1:0]         adv_i,
    input  logic                    mask_we_i,
    input  logic [STAT_W-1:0]       mask_wdata_i,
    input  logic                    clr_we_i,
    input  logic [STAT_W-1:0]       clr_wdata_i,
    output logic [STAT_W-1:0]       mask_o,
    output logic [STAT_W-1:0]       status_o,
    output logic [NREG*PTR_W-1:0]   ptr_o,
    output logic                    irq_o
);
    logic [NREG-1:0] half_evt;
    logic [NREG-1:0] wrap_evt;

    // One offset tracker per region.
    for (genvar g = 0; g < NREG; g++) begin : g_region
        rim_region_tracker #(
            .MIN_LOG2 (MIN_LOG2),
            .MAX_LOG2 (MAX_LOG2),
            .SEL_W    (SEL_W)
        ) i_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (size_sel_i[g*SEL_W +: SEL_W]),
            .adv_i      (adv_i[g]),
            .off_o      (ptr_o[g*PTR_W +: PTR_W]),
            .half_evt_o (half_evt[g]),
            .wrap_evt_o (wrap_evt[g])
        );
    end

    rim_status_bank #(
        .NREG    (NREG),
        .FULL_EN (FULL_EN)
    ) i_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_evt_i   (half_evt),
        .wrap_evt_i   (wrap_evt),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .clr_we_i     (clr_we_i),
        .clr_wdata_i  (clr_wdata_i),
        .mask_o       (mask_o),
        .status_o     (status_o)
    );

    // Combined request: any pending bit that is still unmasked.
    always_comb begin
        irq_o = |(status_o & mask_o);
    end
endmodule

// File: rtl/rollover_irq_monitor_chk.sv
// Module: rollover_irq_monitor_chk
// Temporal checks on the monitor's ports, attached to the top by bind.
module rollover_irq_monitor_chk #(
    parameter int              NREG    = 4,
    parameter int              PTR_W   = 13,
    parameter logic [NREG-1:0] FULL_EN = 4'b0011,
    localparam int             STAT_W  = 2 * NREG
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NREG-1:0]       adv_i,
    input logic                  mask_we_i,
    input logic                  clr_we_i,
    input logic [STAT_W-1:0]     clr_wdata_i,
    input logic [STAT_W-1:0]     mask_o,
    input logic [STAT_W-1:0]     status_o,
    input logic [NREG*PTR_W-1:0] ptr_o,
    input logic                  irq_o
);
    // R5: no status bit rises unless its mask bit was set.
    p_masked_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(mask_o)) == '0));

    // R6: a status bit falls only when a clear write named it.
    p_clear_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_o & $past(status_o) &
                   ~($past(clr_we_i) ? $past(clr_wdata_i) : '0)) == '0));

    // R8: the request falls only after a mask or clear write.
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(clr_we_i || mask_we_i));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // R3: a half bit rises only after its region advanced.
        p_half_from_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_o[g]) |-> $past(adv_i[g]));

        // R1: without an advance the offset holds.
        p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !adv_i[g] |=> $stable(ptr_o[g*PTR_W +: PTR_W]) || $past(!rst_n));

        if (FULL_EN[g]) begin : g_full
            // R4: an unmasked wrap to zero sets the full bit.
            p_wrap_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(adv_i[g]) && $past(mask_o[NREG+g]) &&
                 (ptr_o[g*PTR_W +: PTR_W] == '0) &&
                 ($past(ptr_o[g*PTR_W +: PTR_W]) != '0)) |-> status_o[NREG+g]);
        end else begin : g_nofull
            // R4: regions without a full bit never report one.
            p_no_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !status_o[NREG+g] && !mask_o[NREG+g]);
        end
    end
endmodule

bind rollover_irq_monitor rollover_irq_monitor_chk #(
    .NREG    (NREG),
    .PTR_W   (PTR_W),
    .FULL_EN (FULL_EN)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv_i),
    .mask_we_i   (mask_we_i),
    .clr_we_i    (clr_we_i),
    .clr_wdata_i (clr_wdata_i),
    .mask_o      (mask_o),
    .status_o    (status_o),
    .ptr_o       (ptr_o),
    .irq_o       (irq_o)
);

// File: tb/test_rollover_irq_monitor.sv
// Bench for rollover_irq_monitor: a vector table walked by one loop,
// then directed tests for reset, masking, clearing and collisions.
module test_rollover_irq_monitor;
    localparam int NREG = 4;
    localparam int PW   = 13;
    localparam int SW   = 8;
    localparam int NV   = 11;

    // Vector table: region, advances, expected offset, expected status.
    localparam int T_REG  [NV] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3, 0};
    localparam int T_STEP [NV] = '{63, 1, 63, 1, 128, 128, 64, 64, 256, 256, 200};
    localparam int T_PTR  [NV] = '{63, 64, 127, 0, 128, 0, 64, 0, 256, 0, 72};
    localparam int T_STAT [NV] = '{'h00, 'h01, 'h00, 'h10, 'h02, 'h20, 'h04, 'h00, 'h08, 'h00, 'h11};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NREG*3-1:0] size_sel_i;
    logic [NREG-1:0]   adv_i = '0;
    logic              mask_we_i = 1'b0;
    logic [SW-1:0]     mask_wdata_i = '0;
    logic              clr_we_i = 1'b0;
    logic [SW-1:0]     clr_wdata_i = '0;
    logic [SW-1:0]     mask_o;
    logic [SW-1:0]     status_o;
    logic [NREG*PW-1:0] ptr_o;
    logic              irq_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    rollover_irq_monitor i_rollover_irq_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .size_sel_i   (size_sel_i),
        .adv_i        (adv_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .clr_we_i     (clr_we_i),
        .clr_wdata_i  (clr_wdata_i),
        .mask_o       (mask_o),
        .status_o     (status_o),
        .ptr_o        (ptr_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int ptr_of(input int r);
        return int'(ptr_o[r*PW +: PW]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic advance(input int r, input int n);
        @(negedge clk);
        adv_i[r] = 1'b1;
        repeat (n) @(negedge clk);
        adv_i = '0;
    endtask

    task automatic wr_mask(input int v);
        @(negedge clk);
        mask_we_i = 1'b1;
        mask_wdata_i = SW'(v);
        @(negedge clk);
        mask_we_i = 1'b0;
    endtask

    task automatic wr_clr(input int v);
        @(negedge clk);
        clr_we_i = 1'b1;
        clr_wdata_i = SW'(v);
        @(negedge clk);
        clr_we_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // Sizes 128, 256, 128, 512 words.
        size_sel_i = {3'd2, 3'd0, 3'd1, 3'd0};
        do_reset();

        // R10: reset state.
        chk("R10 ptr", int'(|ptr_o), 0);
        chk("R10 status", int'(status_o), 0);
        chk("R10 mask", int'(mask_o), 0);
        chk("R10 irq", int'(irq_o), 0);

        // R4: only implemented mask bits stick.
        wr_mask('hFF);
        chk("R4 mask bits 7:6", int'(mask_o), 'h3F);

        // R1 R3 R4: table walk.
        for (int i = 0; i < NV; i++) begin
            advance(T_REG[i], T_STEP[i]);
            chk($sformatf("R1 vec%0d ptr", i), ptr_of(T_REG[i]), T_PTR[i]);
            chk($sformatf("R3/R4 vec%0d status", i), int'(status_o), T_STAT[i]);
            wr_clr('hFF);
        end

        // R5: masked event leaves nothing behind.
        do_reset();
        advance(0, 64);
        chk("R5 masked status", int'(status_o), 0);
        chk("R5 masked irq", int'(irq_o), 0);
        wr_mask('h01);
        chk("R5 no late set", int'(status_o), 0);
        advance(0, 64);   // wrap, full bit masked
        advance(0, 64);   // midpoint, half bit unmasked
        chk("R3 half set", int'(status_o), 'h01);
        chk("R8 irq high", int'(irq_o), 1);
        wr_mask('h00);
        chk("R8 irq masked", int'(irq_o), 0);
        chk("R8 status kept", int'(status_o), 'h01);

        // R6: selective clear.
        wr_mask('hFF);
        wr_clr('hFF);
        advance(0, 64);
        advance(0, 64);
        chk("R6 before clear", int'(status_o), 'h11);
        wr_clr('h01);
        chk("R6 partial clear", int'(status_o), 'h10);
        wr_clr('h10);

        // R7: wrap and clear of the same bit in one cycle (offset 64 -> 127 -> 0).
        advance(0, 63);
        @(negedge clk);
        adv_i[0] = 1'b1;
        clr_we_i = 1'b1;
        clr_wdata_i = 8'h10;
        @(negedge clk);
        adv_i = '0;
        clr_we_i = 1'b0;
        chk("R7 set wins", int'(status_o), 'h10);
        chk("R7 ptr", ptr_of(0), 0);
        wr_clr('hFF);

        // R9: midpoint on region 0 and wrap on region 1 in one cycle.
        advance(0, 63);
        advance(1, 255);
        wr_clr('hFF);
        @(negedge clk);
        adv_i = 4'b0011;
        @(negedge clk);
        adv_i = '0;
        chk("R9 both recorded", int'(status_o), 'h21);
        wr_clr('hFF);

        // R2: largest size codes on region 3.
        size_sel_i[9 +: 3] = 3'd6;
        advance(3, 4095);
        chk("R2 before mid 8192", int'(status_o), 0);
        advance(3, 1);
        chk("R2 mid 8192 status", int'(status_o), 'h08);
        chk("R2 mid 8192 ptr", ptr_of(3), 4096);
        size_sel_i[9 +: 3] = 3'd7;
        advance(3, 4096);
        chk("R2 code7 wraps at 8192", ptr_of(3), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule